// File: doc/BRIEF.md
# Bridge Read Prefetch Controller

When a bus bridge forwards a memory read, this block decides how many bytes it fetches on the target side. The caller gives it the read command type, the start address and a set of control fields for the current direction. The block works out a total fetch length from these. It then hands the fetch out as a series of requests over a valid/ready handshake. No request is larger than a 128-byte sector, and no request crosses a sector boundary. The block also keeps count of how much room is left in a four-sector (512-byte) prefetch buffer.

When a sector is drained and freed, a new sector of fetching may start. In this way a read longer than the buffer keeps the buffer topped up until the whole length has been requested. When the bridge faces a split-transaction bus, the length is also capped by a split commitment limit. In that mode a disconnect by the requester does not stop the fetch. On a conventional bus, a disconnect abandons the fetch at once.

An optional adaptive mode learns from how past bursts ended. It tunes the number of cache lines that the "to cache-line boundary" policy fetches. Each finished read is recorded from the requester's disconnect and the number of bytes it actually used.

Top module: `rd_prefetch_ctrl`

## Requirements
- R1: For a plain memory read (cmd_i = 0), mr_pol_i picks the policy: 0 fetches one DWORD (4 − addr_i[1:0] bytes), 1 fetches to the cache-line boundary, and 2 or 3 fill the buffer.
- R2: For read line (cmd_i = 1) and read multiple (cmd_i = 2 or 3), mrlm_pol_i = 0 fetches to the cache-line boundary and mrlm_pol_i = 1 fills the buffer.
- R3: The cache-line boundary length is lines × L − (addr_i mod L), where L = 4 × cls_dw_i bytes (a power of two). Here lines is 1 unless adaptive mode is active.
- R4: In fill mode on a conventional bus, the total requested equals max_bytes_i. A total of zero gives a done pulse and no request.
- R5: Each request has a length from 1 to 128, and req_addr_o[6:0] + req_len_o ≤ 128. Successive requests cover the range in order, with no gaps. While req_valid_o is high and req_ready_i is low (and no disconnect occurs), the address and length hold steady.
- R6: At most four sectors are requested but not yet freed. Each sect_free_i pulse during a fetch allows one more request, until the total is reached.
- R7: When pcix_mode_i = 1, the fill total is the smaller of max_bytes_i and split_lim_i.
- R8: With pcix_mode_i = 0, disc_i during a fetch drops req_valid_o and pulses done_o on the next cycle. With pcix_mode_i = 1, disc_i has no effect on the fetch.
- R9: done_o is a one-cycle pulse in the cycle after the final handshake (or the abandon). req_valid_o is low whenever done_o is high.
- R10: Adaptive mode is active when adapt_i ≠ 0 and pcix_mode_i = 0. On each disc_i, the burst is scored:
  - "under" if rd_used_i ≥ the bytes requested by the last read;
  - "over" if the unused bytes are at least one line;
  - neutral otherwise.
  Four same-kind results in a row raise or lower the line count by one, clamped to the range 1..8. A neutral result or a change of kind restarts the streak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse: begin a new read, sampled when idle |
| cmd_i | input | 2 | Read command: 0 plain, 1 line, 2/3 multiple |
| addr_i | input | ADDR_W | Start byte address |
| mr_pol_i | input | 2 | Policy for plain memory reads |
| mrlm_pol_i | input | 1 | Policy for read line / read multiple |
| max_bytes_i | input | LEN_W | Maximum read byte count |
| pcix_mode_i | input | 1 | Target side is a split-transaction bus |
| split_lim_i | input | LEN_W | Split commitment byte limit |
| cls_dw_i | input | 8 | Cache-line size in DWORDs |
| adapt_i | input | 2 | Adaptive prefetch enable field |
| disc_i | input | 1 | Requester disconnect pulse |
| rd_used_i | input | LEN_W | Bytes the requester consumed, valid with disc_i |
| sect_free_i | input | 1 | Pulse: one buffer sector drained and freed |
| req_ready_i | input | 1 | Target side accepts the request |
| req_valid_o | output | 1 | Fetch request valid |
| req_addr_o | output | ADDR_W | Fetch request address |
| req_len_o | output | LEN_W | Fetch request byte length |
| done_o | output | 1 | Pulse: fetch complete or abandoned |

## Verification
The length policies are driven with the start address at different alignments:
- a DWORD read from a mid-DWORD address;
- a line read starting mid-line;
- a fill that starts mid-sector.

Each of these separates the offset arithmetic from plain length selection. Fill reads are run three ways: below the buffer size, above it while sector frees are withheld, and then with frees released. This separates the credit stall from the total cap. The same fill is repeated with a tighter split limit to show the split cap applying.

Disconnects are applied with the target stalled, once on each bus type, to show abandon versus continue. Adaptive runs feed chains of under, over and neutral outcomes. These expose the streak length, the reset of the streak, the lower clamp, and the gating of adaptive mode by bus type.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    CMD_MR  = 2'd0,
    CMD_MRL = 2'd1,
    CMD_MRM = 2'd2,
    CMD_MRX = 2'd3
  } rd_cmd_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } seq_st_e;
endpackage

// File: rtl/pf_len_calc.sv
module pf_len_calc #(
  parameter int LEN_W  = 13,
  parameter int LINE_W = 4
) (
  input  logic [1:0]        cmd_i,
  input  logic [LEN_W-1:0]  addr_lo_i,
  input  logic [1:0]        mr_pol_i,
  input  logic              mrlm_pol_i,
  input  logic [LEN_W-1:0]  max_bytes_i,
  input  logic              pcix_i,
  input  logic [LEN_W-1:0]  split_lim_i,
  input  logic [7:0]        cls_dw_i,
  input  logic [LINE_W-1:0] lines_i,
  output logic [LEN_W-1:0]  total_o,
  output logic [LEN_W-1:0]  line_bytes_o
);
  import pf_pkg::*;

  logic [LEN_W-1:0] lb, offs, span, cap, dw_len;

  always_comb begin
    lb     = LEN_W'(cls_dw_i) << 2;
    offs   = addr_lo_i & (lb - LEN_W'(1));
    span   = LEN_W'(lines_i) * lb - offs;
    cap    = (pcix_i && (split_lim_i < max_bytes_i)) ? split_lim_i : max_bytes_i;
    dw_len = LEN_W'(3'd4 - {1'b0, addr_lo_i[1:0]});
    case (rd_cmd_e'(cmd_i))
      CMD_MR: begin
        case (mr_pol_i)
          2'd0:    total_o = dw_len;
          2'd1:    total_o = span;
          default: total_o = cap;
        endcase
      end
      default: total_o = mrlm_pol_i ? cap : span;
    endcase
    line_bytes_o = lb;
  end
endmodule

// File: rtl/pf_adapt.sv
module pf_adapt #(
  parameter int LEN_W     = 13,
  parameter int LINE_W    = 4,
  parameter int MAX_LINES = 8,
  parameter int RUN_LEN   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_i,
  input  logic [LEN_W-1:0]  sent_i,
  input  logic [LEN_W-1:0]  used_i,
  input  logic [LEN_W-1:0]  line_bytes_i,
  output logic [LINE_W-1:0] lines_o
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic [LINE_W-1:0] lines_q, lines_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, streak;
  logic              dir_q, dir_n;
  logic              under, over, same;

  always_comb begin
    under   = used_i >= sent_i;
    over    = !under && ((sent_i - used_i) >= line_bytes_i);
    same    = (cnt_q != '0) && (dir_q == under);
    streak  = same ? cnt_q + CNT_W'(1) : CNT_W'(1);
    lines_n = lines_q;
    cnt_n   = cnt_q;
    dir_n   = dir_q;
    if (ev_i) begin
      if (under || over) begin
        dir_n = under;
        if (streak == CNT_W'(RUN_LEN)) begin
          cnt_n = '0;
          if (under && lines_q < LINE_W'(MAX_LINES))
            lines_n = lines_q + LINE_W'(1);
          else if (over && lines_q > LINE_W'(1))
            lines_n = lines_q - LINE_W'(1);
        end else begin
          cnt_n = streak;
        end
      end else begin
        cnt_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= LINE_W'(1);
      cnt_q   <= '0;
      dir_q   <= 1'b0;
    end else if (ev_i) begin
      lines_q <= lines_n;
      cnt_q   <= cnt_n;
      dir_q   <= dir_n;
    end
  end

  assign lines_o = lines_q;

  // R10: line count stays inside its clamp range
  assert_lines_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lines_q >= LINE_W'(1)) && (lines_q <= LINE_W'(MAX_LINES)));
  // R10: line count only moves on a scored burst
  assert_lines_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lines_q != $past(lines_q)) |-> $past(ev_i));
endmodule

// File: rtl/pf_seq.sv
module pf_seq #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 13,
  parameter int SECT_BYTES = 128,
  parameter int BUF_SECT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  total_i,
  input  logic              pcix_i,
  input  logic              disc_i,
  input  logic              sect_free_i,
  input  logic              req_ready_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              done_o,
  output logic [LEN_W-1:0]  sent_o
);
  import pf_pkg::*;

  localparam int OFF_W = $clog2(SECT_BYTES);
  localparam int CR_W  = $clog2(BUF_SECT + 1);

  seq_st_e           st_q, st_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [LEN_W-1:0]  rem_q, rem_n, sent_q, sent_n, room, chunk;
  logic [CR_W-1:0]   cred_q, cred_n, cred_dec;
  logic              pcix_q, pcix_n, done_q, done_n;
  logic              fire, last, abandon;

  always_comb begin
    room        = LEN_W'(SECT_BYTES) - LEN_W'(addr_q[OFF_W-1:0]);
    chunk       = (rem_q < room) ? rem_q : room;
    req_valid_o = (st_q == SQ_RUN) && (rem_q != '0) && (cred_q != '0);
    fire        = req_valid_o && req_ready_i;
    last        = fire && (chunk == rem_q);
    abandon     = (st_q == SQ_RUN) && disc_i && !pcix_q;
    cred_dec    = cred_q - CR_W'(fire);

    st_n   = st_q;
    addr_n = addr_q;
    rem_n  = rem_q;
    sent_n = sent_q;
    pcix_n = pcix_q;
    done_n = 1'b0;
    cred_n = (sect_free_i && cred_dec < CR_W'(BUF_SECT)) ? cred_dec + CR_W'(1) : cred_dec;

    if (st_q == SQ_IDLE) begin
      cred_n = cred_q;
      if (start_i) begin
        addr_n = addr_i;
        rem_n  = total_i;
        sent_n = '0;
        pcix_n = pcix_i;
        cred_n = CR_W'(BUF_SECT);
        if (total_i == '0) done_n = 1'b1;
        else               st_n   = SQ_RUN;
      end
    end else if (abandon) begin
      st_n   = SQ_IDLE;
      done_n = 1'b1;
    end else if (fire) begin
      addr_n = addr_q + ADDR_W'(chunk);
      rem_n  = rem_q - chunk;
      sent_n = sent_q + chunk;
      if (last) begin
        st_n   = SQ_IDLE;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      sent_q <= '0;
      cred_q <= '0;
      pcix_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      addr_q <= addr_n;
      rem_q  <= rem_n;
      sent_q <= sent_n;
      cred_q <= cred_n;
      pcix_q <= pcix_n;
      done_q <= done_n;
    end
  end

  assign req_addr_o = addr_q;
  assign req_len_o  = chunk;
  assign done_o     = done_q;
  assign sent_o     = sent_q;

  // R5: request fits one sector
  assert_in_sector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_len_o != '0) &&
      ((LEN_W'(req_addr_o[OFF_W-1:0]) + req_len_o) <= LEN_W'(SECT_BYTES)));
  // R5: stalled request holds
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i && !disc_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_len_o)));
  // R6: outstanding sectors bounded by the buffer
  assert_credit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cred_q <= CR_W'(BUF_SECT));
  // R9: no request alongside done
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_valid_o);
  // R8: conventional disconnect ends the fetch next cycle
  assert_abandon_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abandon |=> (done_o && !req_valid_o));
endmodule

// File: rtl/rd_prefetch_ctrl.sv
module rd_prefetch_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 13,
  parameter int SECT_BYTES = 128,
  parameter int BUF_SECT   = 4,
  parameter int MAX_LINES  = 8,
  parameter int RUN_LEN    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        mr_pol_i,
  input  logic              mrlm_pol_i,
  input  logic [LEN_W-1:0]  max_bytes_i,
  input  logic              pcix_mode_i,
  input  logic [LEN_W-1:0]  split_lim_i,
  input  logic [7:0]        cls_dw_i,
  input  logic [1:0]        adapt_i,
  input  logic              disc_i,
  input  logic [LEN_W-1:0]  rd_used_i,
  input  logic              sect_free_i,
  input  logic              req_ready_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              done_o
);
  localparam int LINE_W = $clog2(MAX_LINES + 1);

  logic              adapt_on;
  logic [LINE_W-1:0] lines_learned, lines_eff;
  logic [LEN_W-1:0]  total, line_bytes, sent;

  assign adapt_on  = (adapt_i != 2'b00) && !pcix_mode_i;
  assign lines_eff = adapt_on ? lines_learned : LINE_W'(1);

  pf_len_calc #(.LEN_W(LEN_W), .LINE_W(LINE_W)) u_len (
    .cmd_i        (cmd_i),
    .addr_lo_i    (addr_i[LEN_W-1:0]),
    .mr_pol_i     (mr_pol_i),
    .mrlm_pol_i   (mrlm_pol_i),
    .max_bytes_i  (max_bytes_i),
    .pcix_i       (pcix_mode_i),
    .split_lim_i  (split_lim_i),
    .cls_dw_i     (cls_dw_i),
    .lines_i      (lines_eff),
    .total_o      (total),
    .line_bytes_o (line_bytes)
  );

  pf_adapt #(.LEN_W(LEN_W), .LINE_W(LINE_W), .MAX_LINES(MAX_LINES), .RUN_LEN(RUN_LEN)) u_adapt (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_i         (disc_i && adapt_on),
    .sent_i       (sent),
    .used_i       (rd_used_i),
    .line_bytes_i (line_bytes),
    .lines_o      (lines_learned)
  );

  pf_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SECT_BYTES(SECT_BYTES), .BUF_SECT(BUF_SECT)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .addr_i      (addr_i),
    .total_i     (total),
    .pcix_i      (pcix_mode_i),
    .disc_i      (disc_i),
    .sect_free_i (sect_free_i),
    .req_ready_i (req_ready_i),
    .req_valid_o (req_valid_o),
    .req_addr_o  (req_addr_o),
    .req_len_o   (req_len_o),
    .done_o      (done_o),
    .sent_o      (sent)
  );
endmodule

// File: tb/rd_prefetch_ctrl_tb.sv
module rd_prefetch_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, mrlm_pol_i, pcix_mode_i, disc_i, sect_free_i, req_ready_i;
  logic [1:0]  cmd_i, mr_pol_i, adapt_i;
  logic [31:0] addr_i;
  logic [12:0] max_bytes_i, split_lim_i, rd_used_i;
  logic [7:0]  cls_dw_i;
  logic        req_valid_o, done_o;
  logic [31:0] req_addr_o;
  logic [12:0] req_len_o;

  int n_chk = 0, n_fail = 0, n_got = 0, done_seen = 0;
  int got_len [0:15];
  int got_addr[0:15];
  bit finished = 0;

  always #10 clk = ~clk;

  rd_prefetch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i), .addr_i(addr_i),
    .mr_pol_i(mr_pol_i), .mrlm_pol_i(mrlm_pol_i), .max_bytes_i(max_bytes_i),
    .pcix_mode_i(pcix_mode_i), .split_lim_i(split_lim_i), .cls_dw_i(cls_dw_i),
    .adapt_i(adapt_i), .disc_i(disc_i), .rd_used_i(rd_used_i), .sect_free_i(sect_free_i),
    .req_ready_i(req_ready_i), .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
    .req_len_o(req_len_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic start_rd(input int cmd, input int addr, input int mpol, input int lpol,
                          input int maxb, input int pcix, input int split);
    @(negedge clk);
    cmd_i = 2'(cmd); addr_i = addr; mr_pol_i = 2'(mpol); mrlm_pol_i = 1'(lpol);
    max_bytes_i = 13'(maxb); pcix_mode_i = 1'(pcix); split_lim_i = 13'(split);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n_got = 0; done_seen = 0;
  endtask

  task automatic collect(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      if (req_valid_o && req_ready_i && n_got < 16) begin
        got_len[n_got] = int'(req_len_o);
        got_addr[n_got] = int'(req_addr_o);
        n_got++;
      end
      if (done_o) begin
        done_seen = 1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic burst_end(input int used);
    @(negedge clk);
    disc_i = 1'b1; rd_used_i = 13'(used);
    @(negedge clk);
    disc_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 reset valid", int'(req_valid_o), 0);
    chk("R9 reset done", int'(done_o), 0);
  endtask

  task automatic t_dword();
    start_rd(0, 32'h1002, 0, 0, 512, 0, 0);
    collect(10);
    chk("R1 dword count", n_got, 1);
    chk("R1 dword len", got_len[0], 2);
    chk("R9 dword done", done_seen, 1);
  endtask

  task automatic t_line();
    start_rd(0, 32'h1010, 1, 0, 512, 0, 0);
    collect(10);
    chk("R3 midline len", got_len[0], 48);
    chk("R3 midline addr", got_addr[0], 32'h1010);
    start_rd(1, 32'h2000, 3, 0, 512, 0, 0);
    collect(10);
    chk("R2 MRL line count", n_got, 1);
    chk("R2 MRL line len", got_len[0], 64);
  endtask

  task automatic t_fill();
    start_rd(2, 32'h3000, 0, 1, 256, 0, 0);
    collect(10);
    chk("R2 MRM fill count", n_got, 2);
    chk("R4 fill len1", got_len[1], 128);
    chk("R4 fill addr1", got_addr[1], 32'h3080);
    start_rd(0, 32'h4040, 2, 0, 256, 0, 0);
    collect(10);
    chk("R5 unaligned count", n_got, 3);
    chk("R5 unaligned len0", got_len[0], 64);
    chk("R5 unaligned len1", got_len[1], 128);
    chk("R5 unaligned addr2", got_addr[2], 32'h4100);
    chk("R5 unaligned len2", got_len[2], 64);
    start_rd(1, 32'h4400, 0, 1, 0, 0, 0);
    collect(4);
    chk("R4 zero total done", done_seen, 1);
    chk("R4 zero total reqs", n_got, 0);
  endtask

  task automatic t_refill();
    start_rd(1, 32'h8000, 0, 1, 1024, 0, 0);
    collect(12);
    chk("R6 stall count", n_got, 4);
    chk("R6 stall no done", done_seen, 0);
    for (int k = 0; k < 4; k++) begin
      sect_free_i = 1'b1;
      @(negedge clk);
      sect_free_i = 1'b0;
      collect(3);
    end
    chk("R6 refill count", n_got, 8);
    chk("R6 refill last addr", got_addr[7], 32'h8380);
    chk("R6 refill done", done_seen, 1);
  endtask

  task automatic t_split();
    start_rd(1, 32'h9000, 0, 1, 1024, 1, 256);
    collect(12);
    chk("R7 split count", n_got, 2);
    chk("R7 split done", done_seen, 1);
  endtask

  task automatic t_disc();
    req_ready_i = 1'b0;
    start_rd(1, 32'hA000, 0, 1, 512, 0, 0);
    chk("R5 stalled valid", int'(req_valid_o), 1);
    disc_i = 1'b1;
    @(negedge clk);
    disc_i = 1'b0;
    chk("R8 conv abandon done", int'(done_o), 1);
    chk("R8 conv abandon valid", int'(req_valid_o), 0);
    start_rd(1, 32'hB000, 0, 1, 512, 1, 512);
    disc_i = 1'b1;
    @(negedge clk);
    disc_i = 1'b0;
    chk("R8 pcix disc valid", int'(req_valid_o), 1);
    chk("R8 pcix disc done", int'(done_o), 0);
    chk("R5 hold len", int'(req_len_o), 128);
    req_ready_i = 1'b1;
    collect(12);
    chk("R8 pcix full count", n_got, 4);
  endtask

  task automatic line_rd(input int pcix, input int exp, input string tag);
    start_rd(1, 32'hC000, 0, 0, 512, pcix, 4096);
    collect(10);
    chk(tag, got_len[0], exp);
  endtask

  task automatic t_adapt();
    adapt_i = 2'b01;
    for (int k = 0; k < 3; k++) begin
      line_rd(0, 64, "R10 before streak");
      burst_end(64);
    end
    line_rd(0, 64, "R10 before 4th");
    burst_end(64);
    line_rd(0, 128, "R10 raised to 2 lines");
    for (int k = 0; k < 4; k++) burst_end(0);
    line_rd(0, 64, "R10 lowered to 1 line");
    for (int k = 0; k < 4; k++) burst_end(0);
    line_rd(0, 64, "R10 lower clamp");
    for (int k = 0; k < 3; k++) burst_end(64);
    burst_end(1);
    burst_end(64);
    line_rd(0, 64, "R10 neutral resets streak");
    for (int k = 0; k < 3; k++) burst_end(64);
    line_rd(1, 64, "R10 off in pcix mode");
    line_rd(0, 128, "R10 conventional uses learned");
    adapt_i = 2'b00;
    line_rd(0, 64, "R10 disabled field");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 0; cmd_i = 0; addr_i = 0; mr_pol_i = 0; mrlm_pol_i = 0;
    max_bytes_i = 0; pcix_mode_i = 0; split_lim_i = 0; cls_dw_i = 8'd16; adapt_i = 0;
    disc_i = 0; rd_used_i = 0; sect_free_i = 0; req_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dword();
    t_line();
    t_fill();
    t_refill();
    t_split();
    t_disc();
    t_adapt();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule